// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Micropipeline

This block is a chain of identical pipeline stages that move data words by transition signalling. On each side there is a request line, an acknowledge line and a data bundle. A single change of level on a request or acknowledge line, rising or falling, is one event. No line ever returns to zero. A producer first makes its data stable, then flips the request. It may change the data again only after the acknowledge has flipped to match.

Each stage has two parts. The first is a two-input Muller C-element. It joins the incoming request with the pass-done event of the stage's own latch. The second is a capture/pass latch controller. The C-element output is the capture event. The downstream acknowledge is the pass event. The latch's capture-done event serves as both the acknowledge sent upstream and the request sent downstream. For synthesis, every handshake line is sampled on a clock, and the C-element and latch state are held in registers.

Top module: `tpmp_pipeline`

## Requirements
- R1: Each toggle of `in_req`, rising or falling, transfers exactly one word. Both polarities carry the same meaning.
- R2: While `rst_n` is low at a clock edge, all stages become empty and transparent. After that edge `in_ack` and `out_req` read 0.
- R3: `in_ack` changes only in a cycle that follows a cycle with a request pending (`in_req != in_ack`). It changes exactly once for each accepted word.
- R4: `out_req` toggles only when the previous output word was already acknowledged (`out_req == out_ack`). While `out_req != out_ack`, `out_data` stays stable.
- R5: The C-element output changes only when all of its inputs agree with each other and differ from the output. Otherwise it holds its value.
- R6: The latch responds to a capture event one clock later. It holds its data and flips capture-done. It responds to a pass event one clock later by going transparent and flipping pass-done. A capture and a pass are never pending at the same time. While the latch holds, its output is stable.
- R7: Words leave in exactly the order they entered, with no loss and no duplication.
- R8: With the consumer stalled, the pipeline accepts exactly STAGES words. The next request stays unacknowledged until the consumer acknowledges.
- R9: On an empty pipeline, suppose `in_req` toggles before clock edge 1. Then `in_ack` toggles at edge 2 and `out_req` toggles at edge 2*STAGES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Upstream request toggle |
| in_data | input | WIDTH | Upstream data bundle |
| in_ack | output | 1 | Acknowledge toggle to upstream |
| out_req | output | 1 | Request toggle to downstream |
| out_data | output | WIDTH | Data bundle to downstream |
| out_ack | input | 1 | Downstream acknowledge toggle |

## Verification
The first pattern is a single word entering an empty chain. It pins down the per-stage latency and shows that a rising request works. A stalled consumer with a producer that keeps pushing shows whether the chain's capacity is exactly one word per stage, and whether back-pressure reaches the input. A long stream with random producer and consumer gaps drives both request polarities many times. Over that stream, a queue-based model catches any reordering, loss or duplication, and any data change while a request is pending.

// File: rtl/tpmp_pkg.sv
// Package: shared helpers for the transition-signalled pipeline.
// Assumes toggle lines are single bits sampled on the block clock.
package tpmp_pkg;
    // An event is outstanding when the two sides of a toggle pair differ.
    function automatic logic pending(input logic side_a, input logic side_b);
        return side_a ^ side_b;
    endfunction
endpackage

// File: rtl/tpmp_celem.sv
// Module: registered Muller C-element.
// What it does: the output follows the inputs only when all of them agree;
// otherwise it keeps its last value.
// Assumes: inputs are already synchronous to clk.
module tpmp_celem #(
    parameter int INPUTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INPUTS-1:0] c_in,
    output logic              c_out
);
    // State update: set on all-ones, clear on all-zeros, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            c_out <= 1'b0;
        else if (&c_in)
            c_out <= 1'b1;
        else if (~|c_in)
            c_out <= 1'b0;
    end

    // R5: an output change needs agreeing inputs in the previous cycle
    p_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_out) |-> ($past(&c_in) || $past(~|c_in)));
endmodule

// File: rtl/tpmp_latch_ctrl.sv
// Module: capture/pass latch controller.
// What it does: a toggle on cap_ev makes it hold d and flip cap_done. A toggle
// on pass_ev makes it transparent again and flip pass_done.
// Assumes: either polarity of a toggle means the same event; the handshake
// around it never raises both events together.
module tpmp_latch_ctrl
    import tpmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_ev,
    input  logic             pass_ev,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             cap_done,
    output logic             pass_done
);
    logic             held;
    logic [WIDTH-1:0] data_q;
    logic             cap_pend;
    logic             pass_pend;

    // Outstanding events: event line differs from its completion line.
    always_comb begin
        cap_pend  = pending(cap_ev, cap_done);
        pass_pend = pending(pass_ev, pass_done);
    end

    // Latch state: capture holds the data, pass releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            data_q    <= '0;
            cap_done  <= 1'b0;
            pass_done <= 1'b0;
        end else if (cap_pend) begin
            held     <= 1'b1;
            data_q   <= d;
            cap_done <= ~cap_done;
        end else if (pass_pend) begin
            held      <= 1'b0;
            pass_done <= ~pass_done;
        end
    end

    // Output: held word, or the input when transparent.
    always_comb q = held ? data_q : d;

    // R6: capture completes one cycle after it is requested
    p_cap_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pend |=> (cap_done != $past(cap_done)));
    // R6: pass completes one cycle after it is requested
    p_pass_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_pend && !cap_pend) |=> (pass_done != $past(pass_done)));
    // R6: capture and pass are never outstanding together
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_pend && pass_pend));
    // R6: a holding latch keeps its output
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held) && $past(rst_n)) |-> $stable(q));
endmodule

// File: rtl/tpmp_stage.sv
// Module: one micropipeline stage.
// What it does: the C-element joins the incoming request with the latch's
// pass-done event to make the capture event. The downstream acknowledge is
// the pass event. Capture-done goes out as both the upstream acknowledge and
// the downstream request.
// Assumes: the upstream keeps data stable while its request is pending.
module tpmp_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             ack_out,
    output logic             req_out,
    output logic [WIDTH-1:0] data_out,
    input  logic             ack_in
);
    logic       cap_ev;
    logic       cap_done;
    logic       pass_done;
    logic [1:0] join_in;

    // C-element inputs: new request, and the latch being free again.
    always_comb join_in = {req_in, ~pass_done};

    tpmp_celem #(.INPUTS(2)) u_join (
        .clk   (clk),
        .rst_n (rst_n),
        .c_in  (join_in),
        .c_out (cap_ev)
    );

    tpmp_latch_ctrl #(.WIDTH(WIDTH)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_ev    (cap_ev),
        .pass_ev   (ack_in),
        .d         (data_in),
        .q         (data_out),
        .cap_done  (cap_done),
        .pass_done (pass_done)
    );

    // Completion of capture is both handshake outputs.
    always_comb begin
        ack_out = cap_done;
        req_out = cap_done;
    end

    // R4: the stage issues a new request only once the previous one is acknowledged
    p_req_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_out) |-> $past(req_out == ack_in));
    // R4: the outgoing bundle stays put while its request is pending
    p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_out != ack_in) && $past(req_out != ack_in) && $past(rst_n)) |-> $stable(data_out));
endmodule

// File: rtl/tpmp_pipeline.sv
// Module: top of an N-stage transition-signalled pipeline.
// What it does: chains STAGES stages. Each stage's acknowledge feeds the
// stage before it, and each stage's request and data feed the stage after.
// Assumes: handshake inputs are synchronous to clk.
module tpmp_pipeline #(
    parameter int STAGES = 3,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic             out_req,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ack
);
    localparam int NODES = STAGES + 1;

    logic [NODES-1:0] req_chain;
    logic [NODES-1:0] ack_chain;
    logic [WIDTH-1:0] dat_chain [NODES];

    // Edge connections of the chain.
    always_comb begin
        req_chain[0]      = in_req;
        dat_chain[0]      = in_data;
        ack_chain[STAGES] = out_ack;
        in_ack            = ack_chain[0];
        out_req           = req_chain[STAGES];
        out_data          = dat_chain[STAGES];
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        tpmp_stage #(.WIDTH(WIDTH)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_in   (req_chain[s]),
            .data_in  (dat_chain[s]),
            .ack_out  (ack_chain[s]),
            .req_out  (req_chain[s+1]),
            .data_out (dat_chain[s+1]),
            .ack_in   (ack_chain[s+1])
        );
    end

    // R3: input acknowledge only answers a pending request
    p_ack_answers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_ack) |-> $past(in_req != in_ack));
    // R2: reset empties the pipeline
    p_reset_empty_r2: assert property (@(posedge clk)
        $past(!rst_n) |-> (!in_ack && !out_req));
endmodule

// File: tb/tpmp_pipeline_tb_top.sv
module tpmp_pipeline_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 3;
    localparam int WIDTH      = 8;
    localparam int N_RANDOM   = 300;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_req = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_ack;
    logic             out_req;
    logic [WIDTH-1:0] out_data;
    logic             out_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    int accepted = 0;
    int delivered = 0;
    bit cons_hold = 1'b1;
    bit done = 1'b0;
    logic [WIDTH-1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tpmp_pipeline #(.STAGES(STAGES), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Present a word and flip the request, at a falling edge.
    task automatic put(input logic [WIDTH-1:0] d);
        @(negedge clk);
        in_data = d;
        exp_q.push_back(d);
        in_req = ~in_req;
    endtask

    task automatic wait_ack();
        while (in_ack != in_req) @(negedge clk);
    endtask

    // Consumer: checks order (R7) and acknowledges after a random delay.
    initial begin
        forever begin
            @(negedge clk);
            if (!cons_hold && out_req != out_ack) begin
                repeat ($urandom % 4) @(negedge clk);
                if (exp_q.size() == 0)
                    check(1'b0, "R7 duplicate word", int'(out_data), -1);
                else begin
                    check(out_data == exp_q[0], "R7 order", int'(out_data), int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
                delivered++;
                out_ack = ~out_ack;
            end
        end
    end

    // Monitor just after each rising edge: handshake rules (R3, R4, R6, R8).
    initial begin
        logic             p_inreq = 1'b0, p_inack = 1'b0, p_oreq = 1'b0, p_oack = 1'b0;
        logic [WIDTH-1:0] p_odata = '0;
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                if (in_ack != p_inack) begin
                    accepted++;
                    check(p_inreq != p_inack, "R3 ack without request", int'(in_ack), int'(p_inack));
                end
                if ((out_req != out_ack) && (p_oreq != p_oack) && (out_req == p_oreq))
                    check(out_data == p_odata, "R4/R6 output data held", int'(out_data), int'(p_odata));
                if (accepted - delivered > STAGES)
                    check(1'b0, "R8 occupancy", accepted - delivered, STAGES);
            end
            p_inreq = in_req; p_inack = in_ack; p_oreq = out_req; p_oack = out_ack; p_odata = out_data;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ack == 1'b0, "R2 in_ack after reset", int'(in_ack), 0);
        check(out_req == 1'b0, "R2 out_req after reset", int'(out_req), 0);
        rst_n = 1'b1;

        // Single word, rising request, consumer held: latency R9.
        put(8'hA5);
        @(negedge clk);
        check(in_ack == 1'b0, "R9 in_ack before edge 2", int'(in_ack), 0);
        @(negedge clk);
        check(in_ack == 1'b1, "R9 in_ack at edge 2", int'(in_ack), 1);
        repeat (2*STAGES - 3) @(negedge clk);
        check(out_req == 1'b0, "R9 out_req before edge 2*STAGES", int'(out_req), 0);
        @(negedge clk);
        check(out_req == 1'b1, "R9 out_req at edge 2*STAGES", int'(out_req), 1);
        check(out_data == 8'hA5, "R1 rising request word", int'(out_data), 8'hA5);
        cons_hold = 1'b0;
        wait (exp_q.size() == 0);

        // Falling request carries a word just the same: R1.
        put(8'h3C);
        wait_ack();
        check(in_ack == 1'b0, "R1 falling request acknowledged", int'(in_ack), 0);
        wait (exp_q.size() == 0);
        check(delivered == 2, "R1 one word per toggle", delivered, 2);

        // Stalled consumer: capacity R8, C-element waits for pass (R5).
        cons_hold = 1'b1;
        for (int i = 0; i < STAGES; i++) begin
            put(WIDTH'(8'h10 + i));
            wait_ack();
        end
        put(8'h77);
        repeat (6*STAGES) @(negedge clk);
        check(in_ack != in_req, "R8/R5 extra word held off", int'(in_ack), int'(~in_req));
        check(out_data == 8'h10, "R8 oldest word at output", int'(out_data), 8'h10);
        check(accepted - delivered == STAGES, "R8 words stored", accepted - delivered, STAGES);
        cons_hold = 1'b0;
        wait_ack();
        wait (exp_q.size() == 0);
        check(delivered == STAGES + 3, "R7 stall words all delivered", delivered, STAGES + 3);

        // Random stream, both polarities, random gaps on both sides: R1, R7.
        for (int i = 0; i < N_RANDOM; i++) begin
            repeat ($urandom % 4) @(negedge clk);
            put(WIDTH'($urandom));
            wait_ack();
        end
        wait (exp_q.size() == 0);
        repeat (4*STAGES) @(negedge clk);
        check(delivered == N_RANDOM + STAGES + 3, "R7 no loss or duplication", delivered, N_RANDOM + STAGES + 3);
        check(accepted == delivered, "R3 one ack per word", accepted, delivered);
        check(out_req == out_ack, "R4 no stray output request", int'(out_req), int'(out_ack));
        done = 1'b1;
        finish_run();
    end
endmodule